// File: doc/BRIEF.md
# Hardwired Step-Counter Control Unit

This block is the sequencer of a small 32-bit processor built around one shared internal bus. It turns the opcode of the current instruction, two register selectors, the zero and negative flags, and a memory-complete handshake into the strobes that move values between the program counter, the memory address and data registers, the instruction register, the Y and Z temporaries and the general-purpose register file. It also drives the ALU operation, the ALU input multiplexer, the memory read and write requests, and an end-of-instruction pulse.

A timing-state counter starts at step 1 and advances one step per clock. Every control line is a sum of products of the decoded step, the decoded opcode and the flags. All sixteen instructions share a three-step fetch. Execution then takes one to three more steps. Any step that waits on memory holds the counter until the handshake arrives. End returns the counter to step 1, so the next fetch begins on the following clock.

The instruction word has the opcode in bits 31:28, the destination/first register Ry in bits 27:23, the source register Rx in bits 22:18 and the offset in bits 17:0. The datapath supplies the first three fields as separate inputs. It extracts the offset by itself when `offset_out` is high.

Top module: `hw_step_ctrl`

## Requirements
- R1: During reset, and on the clock after any cycle in which `end_o` is high, the unit is in fetch step 1. In that step it asserts `pc_out`, `mar_in`, `mem_read` and `z_in`, with `alu_op` = 0 (add) and `mux_sel_y` = 0 (constant four). No other strobe is high.
- R2: Fetch step 2 asserts `z_out`, `pc_in`, `y_in` and `mdr_in_ext`. Fetch step 3 asserts `mdr_out` and `ir_in`. The fetch steps do not depend on the opcode.
- R3: In a waiting step (fetch step 2, step 5 of the indirect load, step 6 of the store), the unit stays in that step with unchanged strobes while `mfc` is low. It advances on the clock edge at which `mfc` is high. `end_o` is never high while the unit is waiting.
- R4: For ADD (4), SUB (5), AND (6) and OR (7):
  - step 4 asserts `gpr_out` (index Ry) and `y_in`;
  - step 5 asserts `gpr_out` (index Rx), `mux_sel_y` and `z_in`, with `alu_op` 0, 1, 2 and 3 respectively;
  - step 6 asserts `z_out`, `gpr_in` (index Ry) and `end_o`.
- R5: Register copy (opcode 0) asserts `gpr_out` (index Rx), `gpr_in` (index Ry) and `end_o` in step 4. Immediate load (opcode 1) asserts `offset_out`, `gpr_in` (index Ry) and `end_o` in step 4.
- R6: Indirect load (opcode 2) uses three execute steps:
  - step 4 asserts `gpr_out` (index Rx), `mar_in` and `mem_read`;
  - step 5 asserts `mdr_in_ext` and waits;
  - step 6 asserts `mdr_out`, `gpr_in` (index Ry) and `end_o`.
- R7: Store (opcode 3) uses three execute steps:
  - step 4 asserts `gpr_out` (index Ry) and `mar_in`;
  - step 5 asserts `gpr_out` (index Rx) and `mdr_in_int`;
  - step 6 asserts `mem_write`, waits, and then asserts `end_o`.
- R8: Compare (opcode 8) asserts `offset_out` and `y_in` in step 4. In step 5 it asserts `gpr_out` (index Ry), `mux_sel_y` and `end_o`, with `alu_op` = 1 (subtract). No register or Z load occurs.
- R9: Unconditional branch (opcode 9) asserts `offset_out`, `mux_sel_y` and `z_in` with `alu_op` = 0 in step 4. In step 5 it asserts `z_out`, `pc_in` and `end_o`.
- R10: The conditional branches are branch-if-zero (10, taken when `flag_z` = 1), branch-if-nonzero (11, taken when `flag_z` = 0) and branch-if-minus (12, taken when `flag_n` = 1). Each performs the step-4 actions of R9. When taken it continues into the step 5 of R9. When not taken it also asserts `end_o` in step 4, and `pc_in` is never asserted.
- R11: INC (13), INVERT (14) and SHL (15) take two execute steps:
  - step 4 asserts `gpr_out` (index Ry) and `z_in`, with `mux_sel_y` = 0 and `alu_op` 4, 5 and 6 respectively;
  - step 5 asserts `z_out`, `gpr_in` (index Ry) and `end_o`.
- R12: At most one of `pc_out`, `mdr_out`, `z_out`, `offset_out` and `gpr_out` is high in any cycle. `mem_read` and `mem_write` are never high together.
- R13: A step for which the current opcode defines no action asserts `end_o` alone, so the unit returns to fetch step 1 and cannot lock up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_opcode | input | 4 | Opcode field of the instruction register |
| ir_ry | input | 5 | Ry register field |
| ir_rx | input | 5 | Rx register field |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| mfc | input | 1 | Memory function complete |
| pc_out | output | 1 | PC drives the bus |
| pc_in | output | 1 | PC loads from the bus |
| mar_in | output | 1 | MAR loads from the bus |
| mdr_in_ext | output | 1 | MDR loads from the memory data bus |
| mdr_in_int | output | 1 | MDR loads from the internal bus |
| mdr_out | output | 1 | MDR drives the bus |
| ir_in | output | 1 | IR loads from the bus |
| y_in | output | 1 | Y loads from the bus |
| z_in | output | 1 | Z loads the ALU result |
| z_out | output | 1 | Z drives the bus |
| offset_out | output | 1 | IR offset field drives the bus |
| gpr_out | output | 1 | Register file drives the bus |
| gpr_out_idx | output | 5 | Register driving the bus |
| gpr_in | output | 1 | Register file loads from the bus |
| gpr_in_idx | output | 5 | Register loaded from the bus |
| mux_sel_y | output | 1 | ALU A input: 1 = Y, 0 = constant four |
| alu_op | output | 3 | ALU operation code |
| mem_read | output | 1 | Memory read request |
| mem_write | output | 1 | Memory write request |
| end_o | output | 1 | Last step of the instruction |

## Verification
The assertions assume the following about the inputs:
- `mfc` eventually rises in every waiting step;
- the opcode, the register fields and the flags do not change between a step and the clock edge that ends it;
- the opcode is held for the whole execute phase of an instruction.

The stimulus changes inputs only just after a rising edge and keeps `mfc` low for a few cycles at most. It holds the opcode for each instruction, with one exception: the opcode is deliberately swapped in step 5 to reach an undefined step/opcode combination.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OPC_W   = 4;
    localparam int NUM_OPS = 2 ** OPC_W;

    typedef enum logic [OPC_W-1:0] {
        OP_MOVR = 4'd0,
        OP_MOVI = 4'd1,
        OP_LDM  = 4'd2,
        OP_STM  = 4'd3,
        OP_ADD  = 4'd4,
        OP_SUB  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_CMP  = 4'd8,
        OP_BRA  = 4'd9,
        OP_BRZ  = 4'd10,
        OP_BRNZ = 4'd11,
        OP_BRM  = 4'd12,
        OP_INC  = 4'd13,
        OP_INV  = 4'd14,
        OP_SHL  = 4'd15
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_INC = 3'd4,
        ALU_INV = 3'd5,
        ALU_SHL = 3'd6
    } alu_e;

    typedef struct packed {
        logic pc_out;
        logic pc_in;
        logic mar_in;
        logic mdr_in_ext;
        logic mdr_in_int;
        logic mdr_out;
        logic ir_in;
        logic y_in;
        logic z_in;
        logic z_out;
        logic offset_out;
        logic gpr_out;
        logic gpr_out_rx;
        logic gpr_in;
        logic mux_sel_y;
        logic mem_read;
        logic mem_write;
        logic wait_mfc;
        logic fin;
        alu_e alu;
    } ctl_word_t;

endpackage

// File: rtl/ctl_opdecode.sv
module ctl_opdecode #(
    parameter int OPC_W = 4,
    localparam int NUM_OPS = 2 ** OPC_W
) (
    input  logic [OPC_W-1:0]   opc,
    output logic [NUM_OPS-1:0] op_hot
);

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_dec
        assign op_hot[i] = (opc == OPC_W'(i));
    end

endmodule

// File: rtl/ctl_step_counter.sv
module ctl_step_counter #(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              fin,
    output logic [STEP_W-1:0] step
);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (stall) begin
            state_d.step = state_q.step;
        end else if (fin) begin
            state_d.step = STEP_W'(1);
        end else begin
            state_d.step = state_q.step + STEP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.step <= STEP_W'(1);
        end else begin
            state_q <= state_d;
        end
    end

    assign step = state_q.step;

    // R3: a waiting step keeps its timing state
    a_r3_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(state_q.step));

    // R1: an accepted end restarts at step 1
    a_r1_end_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !stall) |=> (state_q.step == STEP_W'(1)));

    // R13: the counter never reaches the unused zero state
    a_r13_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.step != '0);

endmodule

// File: rtl/ctl_signal_gen.sv
module ctl_signal_gen
    import ctl_pkg::*;
#(
    parameter int STEP_W = 3,
    localparam int MAX_STEP = 2 ** STEP_W - 1
) (
    input  logic [STEP_W-1:0]  step,
    input  logic [NUM_OPS-1:0] op_hot,
    input  logic               flag_z,
    input  logic               flag_n,
    output ctl_word_t          cw
);

    logic [MAX_STEP:0] t;

    for (genvar i = 0; i <= MAX_STEP; i++) begin : g_step
        assign t[i] = (step == STEP_W'(i));
    end

    logic alu_rr, unary, br_any, br_fail, movr, movi, ldm, stm, cmp;
    logic known;

    always_comb begin
        movr    = op_hot[OP_MOVR];
        movi    = op_hot[OP_MOVI];
        ldm     = op_hot[OP_LDM];
        stm     = op_hot[OP_STM];
        cmp     = op_hot[OP_CMP];
        alu_rr  = op_hot[OP_ADD] | op_hot[OP_SUB] | op_hot[OP_AND] | op_hot[OP_OR];
        unary   = op_hot[OP_INC] | op_hot[OP_INV] | op_hot[OP_SHL];
        br_any  = op_hot[OP_BRA] | op_hot[OP_BRZ] | op_hot[OP_BRNZ] | op_hot[OP_BRM];
        br_fail = (op_hot[OP_BRZ] & ~flag_z) | (op_hot[OP_BRNZ] & flag_z)
                | (op_hot[OP_BRM] & ~flag_n);

        known = t[1] | t[2] | t[3] | t[4]
              | (t[5] & (ldm | stm | alu_rr | cmp | (br_any & ~br_fail) | unary))
              | (t[6] & (alu_rr | ldm | stm));

        cw            = '0;
        cw.pc_out     = t[1];
        cw.mar_in     = t[1] | (t[4] & (ldm | stm));
        cw.mem_read   = t[1] | (t[4] & ldm);
        cw.z_in       = t[1] | (t[5] & alu_rr) | (t[4] & (br_any | unary));
        cw.z_out      = t[2] | (t[6] & alu_rr) | (t[5] & (br_any | unary));
        cw.pc_in      = t[2] | (t[5] & br_any);
        cw.y_in       = t[2] | (t[4] & (alu_rr | cmp));
        cw.mdr_in_ext = t[2] | (t[5] & ldm);
        cw.wait_mfc   = t[2] | (t[5] & ldm) | (t[6] & stm);
        cw.mdr_out    = t[3] | (t[6] & ldm);
        cw.ir_in      = t[3];
        cw.offset_out = t[4] & (movi | cmp | br_any);
        cw.gpr_out    = (t[4] & (movr | ldm | stm | alu_rr | unary))
                      | (t[5] & (stm | alu_rr | cmp));
        cw.gpr_out_rx = (t[4] & (movr | ldm)) | (t[5] & (stm | alu_rr));
        cw.gpr_in     = (t[4] & (movr | movi)) | (t[5] & unary) | (t[6] & (alu_rr | ldm));
        cw.mdr_in_int = t[5] & stm;
        cw.mem_write  = t[6] & stm;
        cw.mux_sel_y  = (t[5] & (alu_rr | cmp)) | (t[4] & br_any);
        cw.fin        = (t[4] & (movr | movi | br_fail))
                      | (t[5] & (cmp | br_any | unary))
                      | (t[6] & (alu_rr | ldm | stm))
                      | ~known;

        cw.alu = ALU_ADD;
        if (t[5]) begin
            if (op_hot[OP_SUB] | cmp)  cw.alu = ALU_SUB;
            else if (op_hot[OP_AND])   cw.alu = ALU_AND;
            else if (op_hot[OP_OR])    cw.alu = ALU_OR;
        end else if (t[4]) begin
            if (op_hot[OP_INC])        cw.alu = ALU_INC;
            else if (op_hot[OP_INV])   cw.alu = ALU_INV;
            else if (op_hot[OP_SHL])   cw.alu = ALU_SHL;
        end

        if (!known) begin
            cw     = '0;
            cw.fin = 1'b1;
            cw.alu = ALU_ADD;
        end
    end

    // R13: an undefined step drives no transfer at all
    always_comb begin
        if (!known) begin
            a_r13_undef_quiet: assert (!cw.gpr_in && !cw.pc_in && !cw.mem_write);
        end
    end

endmodule

// File: rtl/hw_step_ctrl.sv
module hw_step_ctrl
    import ctl_pkg::*;
#(
    parameter int STEP_W = 3,
    parameter int REG_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ir_opcode,
    input  logic [REG_W-1:0] ir_ry,
    input  logic [REG_W-1:0] ir_rx,
    input  logic             flag_z,
    input  logic             flag_n,
    input  logic             mfc,
    output logic             pc_out,
    output logic             pc_in,
    output logic             mar_in,
    output logic             mdr_in_ext,
    output logic             mdr_in_int,
    output logic             mdr_out,
    output logic             ir_in,
    output logic             y_in,
    output logic             z_in,
    output logic             z_out,
    output logic             offset_out,
    output logic             gpr_out,
    output logic [REG_W-1:0] gpr_out_idx,
    output logic             gpr_in,
    output logic [REG_W-1:0] gpr_in_idx,
    output logic             mux_sel_y,
    output logic [2:0]       alu_op,
    output logic             mem_read,
    output logic             mem_write,
    output logic             end_o
);

    logic [STEP_W-1:0]  step;
    logic [NUM_OPS-1:0] op_hot;
    ctl_word_t          cw;
    logic               stall;

    ctl_opdecode #(.OPC_W(OPC_W)) u_dec (
        .opc    (ir_opcode),
        .op_hot (op_hot)
    );

    ctl_signal_gen #(.STEP_W(STEP_W)) u_gen (
        .step   (step),
        .op_hot (op_hot),
        .flag_z (flag_z),
        .flag_n (flag_n),
        .cw     (cw)
    );

    assign stall = cw.wait_mfc & ~mfc;

    ctl_step_counter #(.STEP_W(STEP_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .stall (stall),
        .fin   (cw.fin),
        .step  (step)
    );

    assign pc_out      = cw.pc_out;
    assign pc_in       = cw.pc_in;
    assign mar_in      = cw.mar_in;
    assign mdr_in_ext  = cw.mdr_in_ext;
    assign mdr_in_int  = cw.mdr_in_int;
    assign mdr_out     = cw.mdr_out;
    assign ir_in       = cw.ir_in;
    assign y_in        = cw.y_in;
    assign z_in        = cw.z_in;
    assign z_out       = cw.z_out;
    assign offset_out  = cw.offset_out;
    assign gpr_out     = cw.gpr_out;
    assign gpr_out_idx = cw.gpr_out_rx ? ir_rx : ir_ry;
    assign gpr_in      = cw.gpr_in;
    assign gpr_in_idx  = ir_ry;
    assign mux_sel_y   = cw.mux_sel_y;
    assign alu_op      = cw.alu;
    assign mem_read    = cw.mem_read;
    assign mem_write   = cw.mem_write;
    assign end_o       = cw.fin & ~stall;

    // R12: single bus has at most one driver
    a_r12_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_out, mdr_out, z_out, offset_out, gpr_out}));

    // R12: read and write are exclusive
    a_r12_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_read && mem_write));

    // R1: the cycle after end is fetch step 1
    a_r1_fetch_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> (pc_out && mar_in && mem_read && z_in && !mux_sel_y && alu_op == 3'd0));

    // R3: no end while waiting for memory
    a_r3_no_end_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.wait_mfc && !mfc) |-> !end_o);

endmodule

// File: tb/tb_hw_step_ctrl.sv
module tb_hw_step_ctrl;

    localparam int CLK_PERIOD = 10;

    localparam logic [16:0] B_PCO  = 17'h10000;
    localparam logic [16:0] B_PCI  = 17'h08000;
    localparam logic [16:0] B_MARI = 17'h04000;
    localparam logic [16:0] B_MDRX = 17'h02000;
    localparam logic [16:0] B_MDRI = 17'h01000;
    localparam logic [16:0] B_MDRO = 17'h00800;
    localparam logic [16:0] B_IRI  = 17'h00400;
    localparam logic [16:0] B_YI   = 17'h00200;
    localparam logic [16:0] B_ZI   = 17'h00100;
    localparam logic [16:0] B_ZO   = 17'h00080;
    localparam logic [16:0] B_OFS  = 17'h00040;
    localparam logic [16:0] B_GO   = 17'h00020;
    localparam logic [16:0] B_GI   = 17'h00010;
    localparam logic [16:0] B_SELY = 17'h00008;
    localparam logic [16:0] B_RD   = 17'h00004;
    localparam logic [16:0] B_WR   = 17'h00002;
    localparam logic [16:0] B_END  = 17'h00001;

    localparam logic [16:0] F1 = B_PCO | B_MARI | B_RD | B_ZI;
    localparam logic [16:0] F2 = B_ZO | B_PCI | B_YI | B_MDRX;
    localparam logic [16:0] F3 = B_MDRO | B_IRI;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ir_opcode = 4'd0;
    logic [4:0] ir_ry = 5'd0;
    logic [4:0] ir_rx = 5'd0;
    logic       flag_z = 1'b0;
    logic       flag_n = 1'b0;
    logic       mfc = 1'b1;

    logic pc_out, pc_in, mar_in, mdr_in_ext, mdr_in_int, mdr_out, ir_in;
    logic y_in, z_in, z_out, offset_out, gpr_out, gpr_in, mux_sel_y;
    logic mem_read, mem_write, end_o;
    logic [4:0] gpr_out_idx, gpr_in_idx;
    logic [2:0] alu_op;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hw_step_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .ir_ry(ir_ry), .ir_rx(ir_rx),
        .flag_z(flag_z), .flag_n(flag_n), .mfc(mfc),
        .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mdr_in_ext(mdr_in_ext),
        .mdr_in_int(mdr_in_int), .mdr_out(mdr_out), .ir_in(ir_in), .y_in(y_in),
        .z_in(z_in), .z_out(z_out), .offset_out(offset_out), .gpr_out(gpr_out),
        .gpr_out_idx(gpr_out_idx), .gpr_in(gpr_in), .gpr_in_idx(gpr_in_idx),
        .mux_sel_y(mux_sel_y), .alu_op(alu_op), .mem_read(mem_read),
        .mem_write(mem_write), .end_o(end_o)
    );

    // Compares mid-cycle, then moves to just after the next rising edge.
    task automatic chk(input string tag, input logic [16:0] exp, input int alu,
                       input int oi, input int ii);
        logic [16:0] cw;
        logic bad;
        #2;
        cw = {pc_out, pc_in, mar_in, mdr_in_ext, mdr_in_int, mdr_out, ir_in, y_in,
              z_in, z_out, offset_out, gpr_out, gpr_in, mux_sel_y, mem_read,
              mem_write, end_o};
        checks++;
        bad = (cw !== exp);
        if (alu >= 0 && alu_op !== 3'(alu)) bad = 1'b1;
        if (exp[5] && gpr_out_idx !== 5'(oi)) bad = 1'b1;
        if (exp[4] && gpr_in_idx !== 5'(ii)) bad = 1'b1;
        if (bad) begin
            errors++;
            $display("FAIL %s: strobes=%h exp=%h alu=%0d exp_alu=%0d out_idx=%0d exp=%0d in_idx=%0d exp=%0d",
                     tag, cw, exp, alu_op, alu, gpr_out_idx, oi, gpr_in_idx, ii);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic do_fetch(input string tag, input int waits);
        chk({tag, " R1 fetch T1"}, F1, 0, 0, 0);
        mfc = 1'b0;
        for (int k = 0; k < waits; k++) chk({tag, " R3 fetch T2 wait"}, F2, -1, 0, 0);
        mfc = 1'b1;
        chk({tag, " R2 fetch T2"}, F2, -1, 0, 0);
        chk({tag, " R2 fetch T3"}, F3, -1, 0, 0);
    endtask

    task automatic t_alu(input logic [3:0] op, input int code, input int ry, input int rx);
        ir_opcode = op; ir_ry = 5'(ry); ir_rx = 5'(rx);
        do_fetch("R4", 0);
        chk("R4 alu T4", B_GO | B_YI, -1, ry, 0);
        chk("R4 alu T5", B_GO | B_SELY | B_ZI, code, rx, 0);
        chk("R4 alu T6", B_ZO | B_GI | B_END, -1, 0, ry);
    endtask

    task automatic t_moves();
        ir_opcode = 4'd0; ir_ry = 5'd9; ir_rx = 5'd22;
        do_fetch("R5", 0);
        chk("R5 copy T4", B_GO | B_GI | B_END, -1, 22, 9);
        ir_opcode = 4'd1; ir_ry = 5'd30;
        do_fetch("R5", 0);
        chk("R5 imm T4", B_OFS | B_GI | B_END, -1, 0, 30);
    endtask

    task automatic t_ldm(input int waits);
        ir_opcode = 4'd2; ir_ry = 5'd4; ir_rx = 5'd17;
        do_fetch("R6", waits);
        chk("R6 ldm T4", B_GO | B_MARI | B_RD, -1, 17, 0);
        mfc = 1'b0;
        for (int k = 0; k < waits; k++) chk("R6 R3 ldm T5 wait", B_MDRX, -1, 0, 0);
        mfc = 1'b1;
        chk("R6 ldm T5", B_MDRX, -1, 0, 0);
        chk("R6 ldm T6", B_MDRO | B_GI | B_END, -1, 0, 4);
    endtask

    task automatic t_stm(input int waits);
        ir_opcode = 4'd3; ir_ry = 5'd6; ir_rx = 5'd1;
        do_fetch("R7", 0);
        chk("R7 stm T4", B_GO | B_MARI, -1, 6, 0);
        chk("R7 stm T5", B_GO | B_MDRI, -1, 1, 0);
        mfc = 1'b0;
        for (int k = 0; k < waits; k++) chk("R7 R3 stm T6 wait no end", B_WR, -1, 0, 0);
        mfc = 1'b1;
        chk("R7 stm T6", B_WR | B_END, -1, 0, 0);
    endtask

    task automatic t_cmp();
        ir_opcode = 4'd8; ir_ry = 5'd7; ir_rx = 5'd0;
        do_fetch("R8", 0);
        chk("R8 cmp T4", B_OFS | B_YI, -1, 0, 0);
        chk("R8 cmp T5", B_GO | B_SELY | B_END, 1, 7, 0);
    endtask

    task automatic t_branch(input string tag, input logic [3:0] op, input logic z,
                            input logic n, input logic taken);
        ir_opcode = op; flag_z = z; flag_n = n;
        do_fetch(tag, 0);
        if (taken) begin
            chk({tag, " branch T4"}, B_OFS | B_SELY | B_ZI, 0, 0, 0);
            chk({tag, " branch T5 taken"}, B_ZO | B_PCI | B_END, -1, 0, 0);
        end else begin
            chk({tag, " branch T4 not taken"}, B_OFS | B_SELY | B_ZI | B_END, 0, 0, 0);
        end
        flag_z = 1'b0; flag_n = 1'b0;
    endtask

    task automatic t_unary(input logic [3:0] op, input int code, input int ry);
        ir_opcode = op; ir_ry = 5'(ry); ir_rx = 5'd3;
        do_fetch("R11", 0);
        chk("R11 unary T4", B_GO | B_ZI, code, ry, 0);
        chk("R11 unary T5", B_ZO | B_GI | B_END, -1, 0, ry);
    endtask

    task automatic t_undef();
        ir_opcode = 4'd2; ir_ry = 5'd2; ir_rx = 5'd5;
        do_fetch("R13", 0);
        chk("R13 ldm T4", B_GO | B_MARI | B_RD, -1, 5, 0);
        ir_opcode = 4'd1;
        chk("R13 undefined step ends", B_END, -1, 0, 0);
        chk("R13 R1 recovers to fetch", F1, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset state", F1, 0, 0, 0);
        rst_n = 1'b1;
        do_fetch("R2 opcode zero", 2);
        chk("R5 copy after reset", B_GO | B_GI | B_END, -1, 0, 0);
        t_alu(4'd4, 0, 1, 2);
        t_alu(4'd5, 1, 31, 0);
        t_alu(4'd6, 2, 12, 19);
        t_alu(4'd7, 3, 8, 8);
        t_moves();
        t_ldm(0);
        t_ldm(3);
        t_stm(2);
        t_cmp();
        t_branch("R9", 4'd9, 1'b0, 1'b0, 1'b1);
        t_branch("R10 bz", 4'd10, 1'b1, 1'b0, 1'b1);
        t_branch("R10 bz", 4'd10, 1'b0, 1'b1, 1'b0);
        t_branch("R10 bnz", 4'd11, 1'b0, 1'b0, 1'b1);
        t_branch("R10 bnz", 4'd11, 1'b1, 1'b0, 1'b0);
        t_branch("R10 bm", 4'd12, 1'b0, 1'b1, 1'b1);
        t_branch("R10 bm", 4'd12, 1'b1, 1'b0, 1'b0);
        t_unary(4'd13, 4, 5);
        t_unary(4'd14, 5, 14);
        t_unary(4'd15, 6, 27);
        t_undef();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule